// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request port and an external asynchronous static RAM holding 8192 words of 9 bits. A client offers one access at a time with a valid/ready handshake. The access carries a 13-bit address, a 9-bit write word and a write flag. Read results come back on a response port with a one-cycle valid strobe. On the memory side the controller drives registered pins: the address, a split data bus (out, in, drive enable), a select pair with one low-active and one high-active line, a low-active output enable and a low-active write enable.

The memory has no clock, so every timing interval it needs is given in picoseconds as a parameter. The controller rounds each interval up to whole system clock cycles. Read access time, write strobe width, data setup before the end of the write, address valid before the end of the write and the output-enable release time become separate cycle counts. A write is framed by the overlap of both selects and the write strobe, with output enable held high. While no access is in progress the memory is deselected so that it can drop into its low-power standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, req_ready is 1, rsp_valid is 0, mem_dq_oe is 0, and the select pins are parked: mem_sel_n=1, mem_sel=0, mem_oe_n=1, mem_we_n=1.
- R2: Whenever req_ready is 1 the memory is deselected (mem_sel_n=1, mem_sel=0) with mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0.
- R3: A read accepted on clock edge k drives mem_sel_n=0, mem_sel=1, mem_oe_n=0, mem_we_n=1 and the address from edge k onward. It holds these for RD cycles, RD being the larger of the rounded access time and the rounded cycle time. mem_dq_in is captured on edge k+RD, and rsp_valid is high for exactly that one cycle.
- R4: A write that starts driving on edge s holds mem_dq_oe=1 with its address and data from s to s+SU+WE+1. mem_we_n is low from edge s+SU for exactly WE cycles. WE is the larger of the rounded strobe width and the rounded data setup. SU is at least 1 and covers the rest of the address-valid interval. After the strobe there is one hold cycle with mem_we_n=1. The memory stores the driven word.
- R5: mem_we_n is 0 only while mem_sel_n=0, mem_sel=1, mem_oe_n=1 and mem_dq_oe=1.
- R6: While mem_we_n stays 0, mem_addr and mem_dq_out do not change.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0, nor during the first TURN cycles after mem_oe_n rises. TURN is the rounded output-enable release time.
- R8: A write accepted on edge a starts driving on edge max(a, e+TURN), where e is the edge on which the last read completed. Until then the memory stays deselected.
- R9: req_ready is 0 from the acceptance edge until the access ends. It returns to 1 on the completion edge of a read (together with rsp_valid) and on edge s+SU+WE+1 of a write.
- R10: A read returns the word most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 9 | Write word |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | 9 | Read word |
| mem_addr | output | 13 | Memory address pins |
| mem_dq_out | output | 9 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 9 | Data from the memory pads |
| mem_sel_n | output | 1 | Low-active select |
| mem_sel | output | 1 | High-active select |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_we_n | output | 1 | Low-active write strobe |

## Verification
Two things can land on the same clock edge: a read finishing, which returns data, releases output enable and starts the turnaround count, and the acceptance of a following write. The bench provokes this by offering a write in the very cycle ready comes back with the read data. It also offers writes after short idle gaps that end inside or just past the turnaround window. Each write is judged by the first cycle its data drive appears, compared with the completion cycle of the read and the turnaround count. The bench also checks the position and width of the write strobe and the read-back value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RD
  } seq_state_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic oe_n;
    logic we_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_PARK = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

  function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t strobe_of(input seq_state_e s);
    strobe_t p;
    p = STROBE_PARK;
    case (s)
      ST_WSET: begin p.sel_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1; end
      ST_WPUL: begin p.sel_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1; p.we_n = 1'b0; end
      ST_WHLD: begin p.sel_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1; end
      ST_RD:   begin p.sel_n = 1'b0; p.sel = 1'b1; p.oe_n = 1'b0; end
      default: p = STROBE_PARK;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_delay_cnt.sv
module sram_delay_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned SU_CYC   = 1,
  parameter int unsigned WE_CYC   = 2,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    req_write,
  output logic    idle,
  output logic    accept,
  output logic    rd_done,
  output strobe_t strobe_nxt
);

  localparam logic [CNT_W-1:0] PH_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] PH_SU   = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] PH_WE   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] TC_INIT = CNT_W'(TURN_CYC);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] ph_cnt, tc_cnt, ph_val;
  logic             ph_load, tc_load;
  logic             ph_done, tc_clear;

  assign ph_done  = (ph_cnt == '0);
  // turnaround is over on this edge when at most one cycle remains
  assign tc_clear = (tc_cnt <= CNT_W'(1));

  always_comb begin
    st_d    = st_q;
    ph_load = 1'b0;
    ph_val  = '0;
    tc_load = 1'b0;
    accept  = 1'b0;
    rd_done = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (!req_write) begin
            st_d    = ST_RD;
            ph_load = 1'b1;
            ph_val  = PH_RD;
          end else if (tc_clear) begin
            st_d    = ST_WSET;
            ph_load = 1'b1;
            ph_val  = PH_SU;
          end else begin
            st_d = ST_TURN;
          end
        end
      end
      ST_TURN: begin
        if (tc_clear) begin
          st_d    = ST_WSET;
          ph_load = 1'b1;
          ph_val  = PH_SU;
        end
      end
      ST_WSET: begin
        if (ph_done) begin
          st_d    = ST_WPUL;
          ph_load = 1'b1;
          ph_val  = PH_WE;
        end
      end
      ST_WPUL: begin
        if (ph_done) begin
          st_d    = ST_WHLD;
          ph_load = 1'b1;
          ph_val  = '0;
        end
      end
      ST_WHLD: begin
        st_d = ST_IDLE;
      end
      ST_RD: begin
        if (ph_done) begin
          st_d    = ST_IDLE;
          rd_done = 1'b1;
          tc_load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  sram_delay_cnt #(.W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .count    (ph_cnt)
  );

  sram_delay_cnt #(.W(CNT_W)) u_turn (
    .clk      (clk),
    .rst      (rst),
    .load     (tc_load),
    .load_val (TC_INIT),
    .count    (tc_cnt)
  );

  assign idle       = (st_q == ST_IDLE);
  assign strobe_nxt = strobe_of(st_d);

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  strobe_t           strobe_nxt,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output strobe_t           strobe_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= STROBE_PARK;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      strobe_q <= strobe_nxt;
      rvalid_q <= rd_done;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_done) rdata_q <= dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 9,
  parameter int unsigned CLK_PS     = 10000,
  parameter int unsigned T_AA_PS    = 25000,
  parameter int unsigned T_RC_PS    = 25000,
  parameter int unsigned T_PWE_PS   = 20000,
  parameter int unsigned T_SD_PS    = 15000,
  parameter int unsigned T_AW_PS    = 20000,
  parameter int unsigned T_HZOE_PS  = 18000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  localparam int unsigned RD_CYC   = umax(1, umax(cycles_for(T_AA_PS, CLK_PS), cycles_for(T_RC_PS, CLK_PS)));
  localparam int unsigned WE_CYC   = umax(1, umax(cycles_for(T_PWE_PS, CLK_PS), cycles_for(T_SD_PS, CLK_PS)));
  localparam int unsigned AW_CYC   = cycles_for(T_AW_PS, CLK_PS);
  localparam int unsigned SU_CYC   = umax(1, (AW_CYC > WE_CYC) ? (AW_CYC - WE_CYC) : 0);
  localparam int unsigned TURN_CYC = cycles_for(T_HZOE_PS, CLK_PS);
  localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WE_CYC), umax(SU_CYC, TURN_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1) + 1;

  logic    accept, rd_done, idle;
  strobe_t strobe_nxt, strobe_q;

  sram_seq_fsm #(
    .CNT_W    (CNT_W),
    .RD_CYC   (RD_CYC),
    .SU_CYC   (SU_CYC),
    .WE_CYC   (WE_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .idle       (idle),
    .accept     (accept),
    .rd_done    (rd_done),
    .strobe_nxt (strobe_nxt)
  );

  sram_pin_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .strobe_nxt (strobe_nxt),
    .rd_done    (rd_done),
    .dq_in      (mem_dq_in),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dq_out),
    .strobe_q   (strobe_q),
    .rdata_q    (rsp_data),
    .rvalid_q   (rsp_valid)
  );

  assign req_ready = idle;
  assign mem_sel_n = strobe_q.sel_n;
  assign mem_sel   = strobe_q.sel;
  assign mem_oe_n  = strobe_q.oe_n;
  assign mem_we_n  = strobe_q.we_n;
  assign mem_dq_oe = strobe_q.drive;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned DATA_W   = 9,
  parameter int unsigned WE_CYC   = 2,
  parameter int unsigned TURN_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_oe_n,
  input logic              mem_we_n
);

  logic [7:0] since_oe;
  logic [7:0] we_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_oe <= 8'hFF;
      we_run   <= '0;
    end else begin
      if (!mem_oe_n)              since_oe <= '0;
      else if (since_oe != 8'hFF) since_oe <= since_oe + 8'd1;
      if (mem_we_n)             we_run <= '0;
      else if (we_run != 8'hFF) we_run <= we_run + 8'd1;
    end
  end

  p_parked_when_ready_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_rsp_single_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_strobe_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run >= 8'(WE_CYC)));

  p_write_window_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_sel_n && mem_sel && mem_oe_n && mem_dq_oe));

  p_write_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && since_oe >= 8'(TURN_CYC)));

  p_rsp_with_ready_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WE_CYC   (WE_CYC),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe),
  .mem_sel_n  (mem_sel_n),
  .mem_sel    (mem_sel),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int AW     = 13;
  localparam int DW     = 9;
  localparam int CLK_PS = 5000;

  function automatic int to_cyc(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = imax(1, imax((25000 + CLK_PS - 1) / CLK_PS, (25000 + CLK_PS - 1) / CLK_PS));
  localparam int E_WE   = imax(1, imax((20000 + CLK_PS - 1) / CLK_PS, (15000 + CLK_PS - 1) / CLK_PS));
  localparam int E_SU   = imax(1, ((20000 + CLK_PS - 1) / CLK_PS) - E_WE);
  localparam int E_TURN = (18000 + CLK_PS - 1) / CLK_PS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;
  logic          mem_dq_oe, mem_sel_n, mem_sel, mem_oe_n, mem_we_n;

  sram_async_ctrl #(.CLK_PS(CLK_PS)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  always #2.5ns clk = ~clk;

  // external memory model and reference contents
  logic [DW-1:0] sram    [int];
  logic [DW-1:0] ref_mem [int];

  always @(posedge mem_we_n)
    if (!rst && !mem_sel_n && mem_sel) sram[int'(mem_addr)] = mem_dq_out;

  always @* begin
    if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
      mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : '0;
    else
      mem_dq_in = 9'h1A5;
  end

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rd_end = -1000;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // continuous pin rules
  logic          prev_we_low = 1'b0, prev_rsp = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_dq;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_dq_oe) chk(mem_oe_n == 1'b1, "R7", "drive while oe low", mem_oe_n, 1);
      if (!mem_we_n) chk(!mem_sel_n && mem_sel && mem_oe_n, "R5", "write window", {mem_sel_n, mem_sel, mem_oe_n}, 3'b011);
      if (!mem_we_n && prev_we_low) chk(mem_addr == prev_addr && mem_dq_out == prev_dq, "R6", "addr/data moved", mem_dq_out, prev_dq);
      if (req_ready) chk(mem_sel_n && !mem_sel && !mem_dq_oe, "R2", "idle select", {mem_sel_n, mem_sel, mem_dq_oe}, 3'b100);
      if (rsp_valid && prev_rsp) chk(0, "R3", "rsp_valid longer than one cycle", 1, 0);
    end
    prev_we_low = !mem_we_n;
    prev_rsp    = rsp_valid;
    prev_addr   = mem_addr;
    prev_dq     = mem_dq_out;
  end

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int ca;
    logic [DW-1:0] exp;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 0; ca = cyc;
    chk(!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n && mem_addr == a, "R3", "read pins", mem_addr, a);
    while (!rsp_valid) begin
      chk(!req_ready, "R9", "ready during read", req_ready, 0);
      @(negedge clk);
    end
    chk(cyc - ca == E_RD, "R3", "read latency", cyc - ca, E_RD);
    exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
    chk(rsp_data == exp, "R10", "read data", rsp_data, exp);
    chk(req_ready, "R9", "ready with rsp", req_ready, 1);
    rd_end = cyc;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ca, es, f_oe, f_we, n_we;
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0; ca = cyc;
    es = imax(ca, rd_end + E_TURN);
    f_oe = -1; f_we = -1; n_we = 0;
    while (!req_ready) begin
      if (mem_dq_oe && f_oe < 0) f_oe = cyc;
      if (mem_dq_oe) chk(mem_dq_out == d && mem_addr == a, "R4", "write bus value", mem_dq_out, d);
      else chk(mem_sel_n && !mem_sel, "R8", "selected while waiting", mem_sel, 0);
      if (!mem_we_n) begin
        if (f_we < 0) f_we = cyc;
        n_we++;
      end
      @(negedge clk);
    end
    chk(f_oe == es, "R8", "drive start edge", f_oe, es);
    chk(f_we == es + E_SU, "R4", "strobe start", f_we, es + E_SU);
    chk(n_we == E_WE, "R4", "strobe width", n_we, E_WE);
    chk(cyc == es + E_SU + E_WE + 1, "R9", "write release edge", cyc, es + E_SU + E_WE + 1);
    chk(!mem_dq_oe, "R4", "drive released", mem_dq_oe, 0);
    chk(sram.exists(int'(a)) && sram[int'(a)] == d, "R4", "memory stored", sram.exists(int'(a)) ? int'(sram[int'(a)]) : -1, d);
    ref_mem[int'(a)] = d;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_dq_oe, "R1", "reset outputs", {req_ready, rsp_valid, mem_dq_oe}, 3'b100);
    chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n, "R1", "reset pins", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n}, 4'b1011);
    rst = 0;
    @(negedge clk);
    chk(req_ready && mem_sel_n && !mem_sel, "R1", "first cycle after reset", {req_ready, mem_sel_n, mem_sel}, 3'b110);

    // directed corners
    do_read(13'd0);                  // R10 unwritten reads zero
    do_write(13'd0, 9'h1FF);         // R8 write right after read completion
    do_read(13'd0);
    idle(2);
    do_write(13'h1FFF, 9'h001);      // R8 gap ends inside turnaround
    do_read(13'h1FFF);
    idle(E_TURN);
    do_write(13'h0AA, 9'h155);       // R8 gap already past turnaround
    do_write(13'h0AA, 9'h0AA);       // back-to-back writes, no wait
    do_read(13'h0AA);
    do_read(13'h1FFF);               // read after read, no turnaround

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 7) == 0) ? 13'h1FFF : AW'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) do_read(a);
      else do_write(a, DW'($urandom));
      idle($urandom_range(0, 5) == 0 ? $urandom_range(1, 5) : 0);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule